// File: doc/BRIEF.md
# Debug-Port Reset and Interrupt Controller

This block sits behind a four-wire serial debug port and turns instructions loaded into the port's instruction register into two chip-level actions. An external debugger can hold the whole chip in reset and later release it, and it can raise an interrupt that software must acknowledge. The debug port is sampled in the system clock domain: `tck_en` is a one-cycle strobe that marks each rising edge of the debug clock, so the debugger's set and the CPU's clear meet in one clock domain.

Reset is driven by two separate commands, one that asserts and one that negates. The host decides how long reset is held and must keep it active for at least the minimum power-on pulse width. The block never stretches or times the pulse. The interrupt is a sticky flag. It is set when the interrupt instruction is updated, or by scanning a 1 through its one-bit data register. Only a CPU write of 0 clears it. The block also presents the fixed exception code 0x600 and a 4-bit priority, taken from the low nibble of a priority register, to the interrupt logic.

The port controller has sixteen states. Test-Logic-Reset (TS_RESET) goes to Run-Test/Idle (TS_IDLE) on TMS low. Idle goes to Select-DR (TS_SEL_DR) on TMS high. Select-DR leads to Capture-DR (TS_CAP_DR) or to Select-IR (TS_SEL_IR). Capture goes to Shift (TS_SHIFT_DR) or to Exit1 (TS_EXIT1_DR). Shift goes to Exit1. Exit1 leads to Pause (TS_PAUSE_DR) or to Update (TS_UPD_DR). Pause goes to Exit2 (TS_EXIT2_DR). Exit2 returns to Shift or goes to Update. Update goes to Select-DR or to Idle. The IR column has the same shape: TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR and TS_UPD_IR. From Select-IR, TMS high returns to Test-Logic-Reset.

Top module: `dbg_rstirq_ctrl`

## Requirements
- R1: After `rst_n` is released, `chip_rst` and `irq_req` are 0, the controller is in Test-Logic-Reset and the bypass instruction is current.
- R2: The controller follows the sixteen-state sequence on each `tck_en` strobe. Five strobes with `tms` high reach Test-Logic-Reset from any state. In that state the current instruction becomes bypass (0xFF).
- R3: The instruction register is 8 bits wide and shifts LSB first from `tdi` to `tdo`. Capture-IR loads 0x01. The opcodes are 0x21 (reset on), 0x22 (reset off) and 0x23 (interrupt). Every other code selects a one-bit bypass register.
- R4: Updating the IR with 0x21 sets `chip_rst` on the clock edge of that update strobe. Updating with 0x22 clears it on that edge. No other code, and no passage of time, changes it.
- R5: Entering Test-Logic-Reset does not release a `chip_rst` that a command asserted.
- R6: Updating the IR with 0x23 sets `irq_req` on the clock edge of that update strobe.
- R7: `irq_req` stays 1 until a CPU write (`cpu_wr`) with `cpu_wdata` = 0 clears it on that clock edge. A CPU write of 1 has no effect.
- R8: When a debug-side set and a CPU clear fall in the same cycle, the flag ends at 1.
- R9: With 0x23 current, the data path is a one-bit register. Capture-DR loads `irq_req` into it. It shifts `tdi` to `tdo` with one strobe of delay. Update-DR sets the flag when the bit is 1 and does nothing when it is 0. Bypass captures 0 and delays by one strobe.
- R10: `irq_code` is always 0x600, and `irq_prio` equals `prio_reg[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset of this block |
| tck_en | input | 1 | One-cycle strobe marking a debug-clock rising edge |
| tms | input | 1 | Debug mode select |
| tdi | input | 1 | Debug serial data in |
| tdo | output | 1 | Debug serial data out, valid in the shift states |
| cpu_wr | input | 1 | CPU write strobe to the flag register |
| cpu_wdata | input | 1 | CPU write data for the flag bit |
| prio_reg | input | 16 | Priority register contents |
| chip_rst | output | 1 | Chip reset request, active high |
| irq_req | output | 1 | Interrupt request (sticky flag) |
| irq_code | output | 12 | Exception code presented with the interrupt |
| irq_prio | output | 4 | Interrupt priority |

## Verification
Two events can land in one clock cycle: the debug-side set of the interrupt flag and the CPU's clear of it. The set comes either from an IR update with the interrupt opcode or from a Update-DR that carries a 1. The bench raises `cpu_wr` with data 0 in exactly the cycle that carries the update strobe, for both kinds of set. It then expects `irq_req` to read 1 afterwards. The same clear issued one strobe later must bring the flag to 0.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    typedef enum logic [3:0] {
        TS_RESET,
        TS_IDLE,
        TS_SEL_DR,
        TS_CAP_DR,
        TS_SHIFT_DR,
        TS_EXIT1_DR,
        TS_PAUSE_DR,
        TS_EXIT2_DR,
        TS_UPD_DR,
        TS_SEL_IR,
        TS_CAP_IR,
        TS_SHIFT_IR,
        TS_EXIT1_IR,
        TS_PAUSE_IR,
        TS_EXIT2_IR,
        TS_UPD_IR
    } tap_state_t;

    // strobes are qualified with tck_en; in_* are levels
    typedef struct packed {
        logic cap_ir;
        logic sh_ir;
        logic upd_ir;
        logic cap_dr;
        logic sh_dr;
        logic upd_dr;
        logic in_tlr;
        logic in_sh_ir;
        logic in_sh_dr;
    } tap_ctl_t;

    typedef enum logic {
        RS_RUN,
        RS_HELD
    } rst_state_t;

    localparam int          IR_W_DEF   = 8;
    localparam logic [7:0]  OP_RST_ON  = 8'h21;
    localparam logic [7:0]  OP_RST_OFF = 8'h22;
    localparam logic [7:0]  OP_IRQ     = 8'h23;
    localparam logic [7:0]  OP_BYPASS  = 8'hFF;
    localparam logic [7:0]  IR_CAPTURE = 8'h01;
    localparam logic [11:0] EXC_CODE   = 12'h600;

endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
    import dbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tck_en,
    input  logic       tms,
    output tap_state_t state_o,
    output tap_ctl_t   ctl_o
);

    tap_state_t state_q;
    tap_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_RESET:    state_d = tms ? TS_RESET    : TS_IDLE;
            TS_IDLE:     state_d = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_DR:   state_d = tms ? TS_SEL_IR   : TS_CAP_DR;
            TS_CAP_DR:   state_d = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_SHIFT_DR: state_d = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_EXIT1_DR: state_d = tms ? TS_UPD_DR   : TS_PAUSE_DR;
            TS_PAUSE_DR: state_d = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
            TS_EXIT2_DR: state_d = tms ? TS_UPD_DR   : TS_SHIFT_DR;
            TS_UPD_DR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_IR:   state_d = tms ? TS_RESET    : TS_CAP_IR;
            TS_CAP_IR:   state_d = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_SHIFT_IR: state_d = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_EXIT1_IR: state_d = tms ? TS_UPD_IR   : TS_PAUSE_IR;
            TS_PAUSE_IR: state_d = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
            TS_EXIT2_IR: state_d = tms ? TS_UPD_IR   : TS_SHIFT_IR;
            TS_UPD_IR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
            default:     state_d = TS_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TS_RESET;
        end else if (tck_en) begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ctl_o          = '0;
        ctl_o.in_tlr   = (state_q == TS_RESET);
        ctl_o.in_sh_ir = (state_q == TS_SHIFT_IR);
        ctl_o.in_sh_dr = (state_q == TS_SHIFT_DR);
        ctl_o.cap_ir   = tck_en && (state_q == TS_CAP_IR);
        ctl_o.sh_ir    = tck_en && (state_q == TS_SHIFT_IR);
        ctl_o.upd_ir   = tck_en && (state_q == TS_UPD_IR);
        ctl_o.cap_dr   = tck_en && (state_q == TS_CAP_DR);
        ctl_o.sh_dr    = tck_en && (state_q == TS_SHIFT_DR);
        ctl_o.upd_dr   = tck_en && (state_q == TS_UPD_DR);
    end

    assign state_o = state_q;

endmodule

// File: rtl/dbg_instr_reg.sv
module dbg_instr_reg
    import dbg_pkg::*;
#(
    parameter int              IR_W    = IR_W_DEF,
    parameter logic [IR_W-1:0] BYPASS  = OP_BYPASS,
    parameter logic [IR_W-1:0] CAPTURE = IR_CAPTURE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  tap_ctl_t        ctl,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_cur,
    output logic [IR_W-1:0] ir_shift,
    output logic            tdo_bit
);

    logic [IR_W-1:0] sh_q;
    logic [IR_W-1:0] cur_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= CAPTURE;
        end else if (ctl.cap_ir) begin
            sh_q <= CAPTURE;
        end else if (ctl.sh_ir) begin
            sh_q <= {tdi, sh_q[IR_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= BYPASS;
        end else if (ctl.in_tlr) begin
            cur_q <= BYPASS;
        end else if (ctl.upd_ir) begin
            cur_q <= sh_q;
        end
    end

    assign ir_cur   = cur_q;
    assign ir_shift = sh_q;
    assign tdo_bit  = sh_q[0];

endmodule

// File: rtl/dbg_data_regs.sv
module dbg_data_regs
    import dbg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  tap_ctl_t ctl,
    input  logic     sel_irq,
    input  logic     tdi,
    input  logic     flag_i,
    output logic     tdo_bit,
    output logic     dr_set_o
);

    logic byp_q;
    logic irq_sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byp_q <= 1'b0;
        end else if (ctl.cap_dr) begin
            byp_q <= 1'b0;
        end else if (ctl.sh_dr) begin
            byp_q <= tdi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_sh_q <= 1'b0;
        end else if (ctl.cap_dr && sel_irq) begin
            irq_sh_q <= flag_i;
        end else if (ctl.sh_dr && sel_irq) begin
            irq_sh_q <= tdi;
        end
    end

    assign tdo_bit  = sel_irq ? irq_sh_q : byp_q;
    assign dr_set_o = ctl.upd_dr && sel_irq && irq_sh_q;

endmodule

// File: rtl/dbg_cmd_exec.sv
module dbg_cmd_exec
    import dbg_pkg::*;
#(
    parameter int              IR_W   = IR_W_DEF,
    parameter logic [IR_W-1:0] OP_ON  = OP_RST_ON,
    parameter logic [IR_W-1:0] OP_OFF = OP_RST_OFF,
    parameter logic [IR_W-1:0] OP_INT = OP_IRQ
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_ir,
    input  logic [IR_W-1:0] ir_shift,
    input  logic            dr_set,
    input  logic            cpu_wr,
    input  logic            cpu_wdata,
    output logic            chip_rst,
    output logic            irq_flag,
    output logic            irq_set_evt
);

    rst_state_t rs_q;
    rst_state_t rs_d;
    logic       flag_q;
    logic       clr_evt;

    always_comb begin
        rs_d = rs_q;
        unique case (rs_q)
            RS_RUN:  if (upd_ir && ir_shift == OP_ON)  rs_d = RS_HELD;
            RS_HELD: if (upd_ir && ir_shift == OP_OFF) rs_d = RS_RUN;
            default: rs_d = RS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= RS_RUN;
        end else begin
            rs_q <= rs_d;
        end
    end

    always_comb begin
        chip_rst = (rs_q == RS_HELD);
    end

    assign irq_set_evt = (upd_ir && ir_shift == OP_INT) || dr_set;
    assign clr_evt     = cpu_wr && !cpu_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (irq_set_evt) begin
            flag_q <= 1'b1;
        end else if (clr_evt) begin
            flag_q <= 1'b0;
        end
    end

    assign irq_flag = flag_q;

endmodule

// File: rtl/dbg_rstirq_ctrl.sv
module dbg_rstirq_ctrl
    import dbg_pkg::*;
#(
    parameter int              IR_W   = IR_W_DEF,
    parameter int              PRIO_W = 16,
    parameter logic [IR_W-1:0] OP_ON  = OP_RST_ON,
    parameter logic [IR_W-1:0] OP_OFF = OP_RST_OFF,
    parameter logic [IR_W-1:0] OP_INT = OP_IRQ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tck_en,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    input  logic              cpu_wr,
    input  logic              cpu_wdata,
    input  logic [PRIO_W-1:0] prio_reg,
    output logic              chip_rst,
    output logic              irq_req,
    output logic [11:0]       irq_code,
    output logic [3:0]        irq_prio
);

    tap_state_t      tap_state;
    tap_ctl_t        ctl;
    logic [IR_W-1:0] ir_cur;
    logic [IR_W-1:0] ir_shift;
    logic            ir_tdo;
    logic            dr_tdo;
    logic            dr_set_evt;
    logic            sel_irq;
    logic            irq_set_evt;
    logic            upd_ir;

    dbg_tap_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tck_en  (tck_en),
        .tms     (tms),
        .state_o (tap_state),
        .ctl_o   (ctl)
    );

    dbg_instr_reg #(
        .IR_W    (IR_W),
        .BYPASS  ({IR_W{1'b1}}),
        .CAPTURE (IR_W'(1))
    ) u_ir (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .tdi      (tdi),
        .ir_cur   (ir_cur),
        .ir_shift (ir_shift),
        .tdo_bit  (ir_tdo)
    );

    assign sel_irq = (ir_cur == OP_INT);
    assign upd_ir  = ctl.upd_ir;

    dbg_data_regs u_dr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .sel_irq  (sel_irq),
        .tdi      (tdi),
        .flag_i   (irq_req),
        .tdo_bit  (dr_tdo),
        .dr_set_o (dr_set_evt)
    );

    dbg_cmd_exec #(
        .IR_W   (IR_W),
        .OP_ON  (OP_ON),
        .OP_OFF (OP_OFF),
        .OP_INT (OP_INT)
    ) u_exec (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_ir      (upd_ir),
        .ir_shift    (ir_shift),
        .dr_set      (dr_set_evt),
        .cpu_wr      (cpu_wr),
        .cpu_wdata   (cpu_wdata),
        .chip_rst    (chip_rst),
        .irq_flag    (irq_req),
        .irq_set_evt (irq_set_evt)
    );

    always_comb begin
        if (ctl.in_sh_ir) begin
            tdo = ir_tdo;
        end else if (ctl.in_sh_dr) begin
            tdo = dr_tdo;
        end else begin
            tdo = 1'b0;
        end
    end

    assign irq_code = EXC_CODE;
    assign irq_prio = prio_reg[3:0];

endmodule

// File: rtl/dbg_rstirq_chk.sv
module dbg_rstirq_chk
    import dbg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tck_en,
    input logic       tms,
    input logic       cpu_wr,
    input logic       cpu_wdata,
    input logic       chip_rst,
    input logic       irq_req,
    input logic       upd_ir,
    input logic [7:0] ir_next,
    input logic       dr_set,
    input tap_state_t tap_state
);

    logic [2:0] ones_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_cnt <= 3'd0;
        end else if (tck_en) begin
            if (!tms) begin
                ones_cnt <= 3'd0;
            end else if (ones_cnt != 3'd5) begin
                ones_cnt <= ones_cnt + 3'd1;
            end
        end
    end

    p_tlr_after_five_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ones_cnt == 3'd5) |-> (tap_state == TS_RESET));

    p_rst_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_ir && ir_next == OP_RST_ON) |=> chip_rst);

    p_rst_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_ir && ir_next == OP_RST_OFF) |=> !chip_rst);

    p_rst_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_rst && !(upd_ir && ir_next == OP_RST_OFF)) |=> chip_rst);

    p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_ir && ir_next == OP_IRQ) |=> irq_req);

    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !(cpu_wr && !cpu_wdata)) |=> irq_req);

    p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_wdata && !dr_set && !(upd_ir && ir_next == OP_IRQ))
        |=> !irq_req);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_wdata && dr_set) |=> irq_req);

endmodule

bind dbg_rstirq_ctrl dbg_rstirq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tck_en    (tck_en),
    .tms       (tms),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .chip_rst  (chip_rst),
    .irq_req   (irq_req),
    .upd_ir    (upd_ir),
    .ir_next   (ir_shift),
    .dr_set    (dr_set_evt),
    .tap_state (tap_state)
);

// File: tb/dbg_rstirq_ctrl_bench.sv
module dbg_rstirq_ctrl_bench;

    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] C_ON  = 8'h21;
    localparam logic [7:0] C_OFF = 8'h22;
    localparam logic [7:0] C_INT = 8'h23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tck_en = 1'b0;
    logic        tms = 1'b0;
    logic        tdi = 1'b0;
    logic        tdo;
    logic        cpu_wr = 1'b0;
    logic        cpu_wdata = 1'b0;
    logic [15:0] prio_reg = 16'h0;
    logic        chip_rst;
    logic        irq_req;
    logic [11:0] irq_code;
    logic [3:0]  irq_prio;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    bit  m_rst;
    bit  m_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_rstirq_ctrl u_dbg_rstirq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tck_en    (tck_en),
        .tms       (tms),
        .tdi       (tdi),
        .tdo       (tdo),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .prio_reg  (prio_reg),
        .chip_rst  (chip_rst),
        .irq_req   (irq_req),
        .irq_code  (irq_code),
        .irq_prio  (irq_prio)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one debug-clock rising edge; optional CPU clear in the same cycle
    task automatic tick(input logic m, input logic d, input logic clr);
        @(negedge clk);
        tms = m; tdi = d; tck_en = 1'b1;
        cpu_wr = clr; cpu_wdata = 1'b0;
        @(negedge clk);
        tck_en = 1'b0; cpu_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic cpu_write(input logic v);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_wdata = v;
        @(negedge clk);
        cpu_wr = 1'b0;
        @(negedge clk);
    endtask

    // from Idle: load code, return to Idle; returns captured IR bits
    task automatic load_ir(input logic [7:0] code, input logic clr, output logic [7:0] cap);
        tick(1, 0, 0); tick(1, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
        for (int i = 0; i < 8; i++) begin
            cap[i] = tdo;
            tick(i == 7, code[i], 0);
        end
        tick(1, 0, 0);
        tick(0, 0, clr);
    endtask

    // from Idle: capture, shift b1 then b2, update; returns captured and delayed bits
    task automatic scan_dr(input logic b1, input logic b2, input logic clr,
                           output logic cap, output logic mid);
        tick(1, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
        cap = tdo;
        tick(0, b1, 0);
        mid = tdo;
        tick(1, b2, 0);
        tick(1, 0, 0);
        tick(0, 0, clr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] cap8;
        logic       c1, c2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 chip_rst", chip_rst, 0);
        chk("R1 irq_req", irq_req, 0);
        chk("R1 tdo", tdo, 0);
        tick(0, 0, 0);
        scan_dr(1, 0, 0, c1, c2);
        chk("R1 bypass capture", c1, 0);
        chk("R9 bypass delay", c2, 1);

        // R10 fixed code and priority nibble
        for (int p = 0; p < 16; p++) begin
            prio_reg = 16'((p * 16'h1357) ^ (p << 12)) & 16'hFFF0 | 16'(p);
            #1;
            chk("R10 irq_prio", irq_prio, p);
            chk("R10 irq_code", irq_code, 12'h600);
        end

        // R3 R4 R6 R7 R9: sweep every IR code
        m_rst = 0; m_flag = 0;
        for (int c = 0; c < 256; c++) begin
            load_ir(8'(c), 0, cap8);
            chk("R3 capture 0x01", cap8, 8'h01);
            if (8'(c) == C_ON)  m_rst = 1;
            if (8'(c) == C_OFF) m_rst = 0;
            if (8'(c) == C_INT) m_flag = 1;
            chk("R4 chip_rst after code", chip_rst, m_rst);
            chk("R6 irq_req after code", irq_req, m_flag);
            scan_dr(1, 0, 0, c1, c2);
            chk("R9 dr capture", c1, (8'(c) == C_INT) ? m_flag : 1'b0);
            chk("R9 dr one-bit delay", c2, 1);
            chk("R7 flag after update 0", irq_req, m_flag);
            if (m_flag && (c % 4 == 0)) begin
                cpu_write(1);
                chk("R7 write 1 ignored", irq_req, 1);
                cpu_write(0);
                m_flag = 0;
                chk("R7 write 0 clears", irq_req, 0);
            end
            if (c == 200) begin
                load_ir(C_ON, 0, cap8);
                m_rst = 1;
                repeat (20) @(negedge clk);
                chk("R4 reset held over time", chip_rst, 1);
            end
        end
        load_ir(C_OFF, 0, cap8);
        chk("R4 released", chip_rst, 0);

        // R8 set wins: IR update with simultaneous clear
        cpu_write(0);
        load_ir(C_INT, 1, cap8);
        chk("R8 IR set vs clear", irq_req, 1);
        cpu_write(0);
        chk("R7 clear after", irq_req, 0);
        // R9 DR update with 1 sets, with simultaneous clear (R8)
        scan_dr(0, 1, 1, c1, c2);
        chk("R9 capture 0", c1, 0);
        chk("R8 DR set vs clear", irq_req, 1);
        scan_dr(0, 0, 0, c1, c2);
        chk("R9 capture 1", c1, 1);
        chk("R9 update 0 no effect", irq_req, 1);
        cpu_write(0);
        scan_dr(0, 1, 0, c1, c2);
        chk("R9 update 1 sets", irq_req, 1);

        // R2 R5: five TMS-high from assorted states
        for (int n = 0; n < 64; n++) begin
            load_ir(C_ON, 0, cap8);
            load_ir(C_INT, 0, cap8);
            for (int k = 0; k < (n % 7); k++) tick(n[k % 6], 0, 0);
            for (int k = 0; k < 5; k++) tick(1, 0, 0);
            tick(0, 0, 0);
            chk("R5 reset survives TLR", chip_rst, 1);
            scan_dr(0, 0, 0, c1, c2);
            chk("R2 bypass after TLR", c1, 0);
            load_ir(C_OFF, 0, cap8);
            chk("R4 off", chip_rst, 0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule